// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog

This block is an independent watchdog. A 12-bit down-counter is decremented by a prescaled copy of a slow oscillator tick, and the block pulses a reset output when software fails to service it in time. Software talks to it through a small write/read register port. Magic values written to a key register start the watchdog, service (refresh) it, or open the configuration registers for writing. Once running, the watchdog cannot be stopped except by its own reset pulse or the system reset.

The three configuration registers are the prescaler code, the reload value and the window value. Each write lands in a pending copy, and the value takes effect only after a fixed number of prescaled ticks. While a value is pending, a busy flag shows in the status register. The window value makes refreshes arriving too early fatal. Writing it also reloads the counter once the new value takes effect. A debug halt input, gated by a halt-enable input, freezes the counter.

The slow clock appears as a single-cycle enable `slow_tick` in the system clock domain. The register port is a plain control interface with no back-pressure: a write is taken in the cycle `wr_en` is high, and reads are combinational from `rd_addr`.

Top module: `key_watchdog`

## Requirements
- R1: After system reset, `wdt_rst` is 0, `count` is 0xFFF, the prescaler code reads 0, reload and window both read 0xFFF, and status reads 0. The address map is: 0 key, 1 prescaler code, 2 reload, 3 window, 4 status.
- R2: The counter does not move until key 0xCCCC is written. After that write it decrements once per prescaled tick. No later key write or register write stops it.
- R3: When a prescaled tick arrives while the running counter is at 0, `wdt_rst` is asserted. With reload value N, the time from a refresh to the reset is N+1 prescaled ticks.
- R4: Writes to addresses 1–3 take effect only after key 0x5555 has been written. Any other key value withdraws that permission. A write made without permission changes neither the register nor the status.
- R5: A permitted configuration write sets its status bit (bit 0 prescaler, bit 1 reload, bit 2 window) in the next cycle. The bit clears, and the new value becomes readable and active, after 5 prescaled ticks.
- R6: Key 0xAAAA loads the reload value into the counter in the same cycle, provided the refresh is not early.
- R7: `wdt_rst` is high for exactly one system clock cycle per event.
- R8: During the reset pulse, every register is back at its R1 default and the watchdog is stopped.
- R9: While running, a 0xAAAA refresh that arrives with the counter above the window value asserts `wdt_rst` instead of reloading. A window value of 0xFFF disables this check.
- R10: When a window write takes effect, the counter is reloaded from the reload value.
- R11: While `dbg_halt` and `halt_en` are both high, the counter holds its value. With `halt_en` low, `dbg_halt` has no effect.
- R12: Prescaler code k divides `slow_tick` by 4·2^k. Codes above 6 divide by 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| slow_tick | input | 1 | One-cycle enable per low-speed oscillator period |
| dbg_halt | input | 1 | Debug halt request |
| halt_en | input | 1 | Allows `dbg_halt` to freeze the counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| count | output | 12 | Current counter value |

## Verification
The counter is exercised in several ways:
- Left idle before start, to separate a start-gated counter from a free-running one.
- Refreshed with the window disabled, inside the window and above it, which separates a reload from an early-refresh reset.
- Allowed to expire after a short reload, where the measured delay in cycles pins down the N+1 tick count and the divide ratio.

Configuration writes are tried locked, unlocked, and after re-locking with a foreign key. Busy flags are sampled both mid-transfer and after completion. Freeze is tried with the enable set and cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int PDIV_W  = 3;
  localparam int NUM_CFG = 3;

  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY    = 3'd0,
    A_PRESC  = 3'd1,
    A_RELOAD = 3'd2,
    A_WINDOW = 3'd3,
    A_STATUS = 3'd4
  } wdt_addr_e;

  // configuration slots; slot index + 1 is the register address
  localparam int SLOT_PRESC  = 0;
  localparam int SLOT_RELOAD = 1;
  localparam int SLOT_WINDOW = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PDIV_W      = 3,
  parameter int MIN_DIV_LOG = 2,
  parameter int MAX_DIV_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              slow_tick,
  input  logic [PDIV_W-1:0] div_code,
  output logic              cnt_tick
);
  logic [MAX_DIV_LOG-1:0] pre_cnt;
  logic [MAX_DIV_LOG-1:0] terminal;
  int                     dl;

  always_comb begin
    dl = MIN_DIV_LOG + int'(div_code);
    if (dl > MAX_DIV_LOG) dl = MAX_DIV_LOG;
    terminal = {MAX_DIV_LOG{1'b1}} >> (MAX_DIV_LOG - dl);
  end

  assign cnt_tick = slow_tick && (pre_cnt == terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_cnt <= '0;
    else if (clear)     pre_cnt <= '0;
    else if (cnt_tick)  pre_cnt <= '0;
    else if (slow_tick) pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_keydec.sv
module wdt_keydec
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  output logic             refresh_p,
  output logic             running,
  output logic             unlocked
);
  assign refresh_p = key_we && (key_data == KEY_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else if (clear) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else if (key_we) begin
      if (key_data == KEY_START) running <= 1'b1;
      unlocked <= (key_data == KEY_UNLOCK);
    end
  end

  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !clear |=> running);
endmodule

// File: rtl/wdt_cfg_shadow.sv
module wdt_cfg_shadow #(
  parameter int W           = 12,
  parameter int SLOTS       = 3,
  parameter int APPLY_TICKS = 5,
  parameter logic [SLOTS-1:0][W-1:0] RST_VALS = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      cnt_tick,
  input  logic [SLOTS-1:0]          we,
  input  logic [W-1:0]              wdata,
  output logic [SLOTS-1:0][W-1:0]   applied,
  output logic [SLOTS-1:0]          busy,
  output logic [SLOTS-1:0]          apply_p
);
  localparam int TW = $clog2(APPLY_TICKS + 1);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [W-1:0]  pend;
    logic [TW-1:0] timer;

    assign busy[i]    = (timer != '0);
    assign apply_p[i] = cnt_tick && (timer == TW'(1)) && !we[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend       <= RST_VALS[i];
        applied[i] <= RST_VALS[i];
        timer      <= '0;
      end else if (clear) begin
        pend       <= RST_VALS[i];
        applied[i] <= RST_VALS[i];
        timer      <= '0;
      end else if (we[i]) begin
        pend  <= wdata;
        timer <= TW'(APPLY_TICKS);
      end else if (cnt_tick && busy[i]) begin
        timer <= timer - 1'b1;
        if (apply_p[i]) applied[i] <= pend;
      end
    end

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && !cnt_tick && !clear |=> busy[i]);
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         running,
  input  logic         cnt_tick,
  input  logic         freeze,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic step;
  assign step   = running && cnt_tick && !freeze;
  assign expire = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= CNT_MAX;
    else if (clear)                 count <= CNT_MAX;
    else if (load)                  count <= load_val;
    else if (step && count != '0)   count <= count - 1'b1;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !load && !clear |=> $stable(count));
  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !load && !clear |=> $stable(count));
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int APPLY_TICKS = 5,
  parameter int MIN_DIV_LOG = 2,
  parameter int MAX_DIV_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              dbg_halt,
  input  logic              halt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [KEY_W-1:0]  rd_data,
  output logic              wdt_rst,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [NUM_CFG-1:0][CNT_W-1:0] CFG_RST = {CNT_MAX, CNT_MAX, {CNT_W{1'b0}}};

  logic                          fire, expire, early;
  logic                          refresh_p, running, unlocked, cnt_tick;
  logic [NUM_CFG-1:0]            cfg_we, busy, apply_p;
  logic [NUM_CFG-1:0][CNT_W-1:0] applied;
  logic                          key_we, cnt_load;
  logic [CNT_W-1:0]              window_v, reload_v;

  assign key_we = wr_en && (wr_addr == A_KEY);

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_we
    assign cfg_we[i] = wr_en && unlocked && (wr_addr == ADDR_W'(i + 1));
  end

  assign window_v = applied[SLOT_WINDOW];
  assign reload_v = applied[SLOT_RELOAD];

  assign early    = refresh_p && running && (window_v != CNT_MAX) && (count > window_v);
  assign fire     = expire || early;
  assign cnt_load = (refresh_p && !early) || apply_p[SLOT_WINDOW];

  wdt_keydec u_keydec (
    .clk(clk), .rst_n(rst_n), .clear(fire),
    .key_we(key_we), .key_data(wr_data),
    .refresh_p(refresh_p), .running(running), .unlocked(unlocked)
  );

  wdt_prescaler #(
    .PDIV_W(PDIV_W), .MIN_DIV_LOG(MIN_DIV_LOG), .MAX_DIV_LOG(MAX_DIV_LOG)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(fire || apply_p[SLOT_PRESC]),
    .slow_tick(slow_tick), .div_code(applied[SLOT_PRESC][PDIV_W-1:0]),
    .cnt_tick(cnt_tick)
  );

  wdt_cfg_shadow #(
    .W(CNT_W), .SLOTS(NUM_CFG), .APPLY_TICKS(APPLY_TICKS), .RST_VALS(CFG_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .clear(fire), .cnt_tick(cnt_tick),
    .we(cfg_we), .wdata(wr_data[CNT_W-1:0]),
    .applied(applied), .busy(busy), .apply_p(apply_p)
  );

  wdt_downcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(fire), .running(running),
    .cnt_tick(cnt_tick), .freeze(dbg_halt && halt_en),
    .load(cnt_load), .load_val(reload_v),
    .count(count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst <= 1'b0;
    else        wdt_rst <= fire;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_PRESC:  rd_data = KEY_W'(applied[SLOT_PRESC]);
      A_RELOAD: rd_data = KEY_W'(reload_v);
      A_WINDOW: rd_data = KEY_W'(window_v);
      A_STATUS: rd_data = KEY_W'(busy);
      default:  rd_data = '0;
    endcase
  end

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R8
  rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (count == CNT_MAX) && !running && (busy == '0));
  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !unlocked && (busy == '0) |=> (busy == '0));
  // R9
  early_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_p && running && (window_v != CNT_MAX) && (count > window_v) |=> wdt_rst);
endmodule

// File: tb/key_watchdog_bench.sv
`timescale 1ns/1ps
module key_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b1;
  logic        dbg_halt = 1'b0;
  logic        halt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wdt_rst;
  logic [11:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  key_watchdog u_key_watchdog (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
    .halt_en(halt_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst(wdt_rst), .count(count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    check(wdt_rst == 1'b0, "R1 rst low", wdt_rst, 0);
    check(count == 12'hFFF, "R1 count", count, 12'hFFF);
    read_reg(3'd1, v); check(v == 16'h0, "R1 presc", v, 0);
    read_reg(3'd2, v); check(v == 16'hFFF, "R1 reload", v, 12'hFFF);
    read_reg(3'd3, v); check(v == 16'hFFF, "R1 window", v, 12'hFFF);
    read_reg(3'd4, v); check(v == 16'h0, "R1 status", v, 0);
  endtask

  task automatic t_not_started();
    wait_cyc(100);
    check(count == 12'hFFF, "R2 idle before start", count, 12'hFFF);
  endtask

  task automatic t_locked_write();
    logic [15:0] v;
    bus_write(3'd2, 16'h0010);
    read_reg(3'd4, v); check(v == 16'h0, "R4 locked status", v, 0);
    wait_cyc(40);
    read_reg(3'd2, v); check(v == 16'hFFF, "R4 locked reload", v, 12'hFFF);
  endtask

  task automatic t_busy_apply();
    logic [15:0] v;
    bus_write(3'd0, 16'h5555);
    bus_write(3'd2, 16'h000A);
    wait_cyc(9);
    read_reg(3'd4, v); check(v == 16'h2, "R5 busy set", v, 2);
    read_reg(3'd2, v); check(v == 16'hFFF, "R5 old value while busy", v, 12'hFFF);
    wait_cyc(21);
    read_reg(3'd4, v); check(v == 16'h0, "R5 busy clear", v, 0);
    read_reg(3'd2, v); check(v == 16'h00A, "R5 reload applied", v, 16'h00A);
  endtask

  task automatic t_relock();
    logic [15:0] v;
    bus_write(3'd0, 16'h5555);
    bus_write(3'd0, 16'h1234);
    bus_write(3'd3, 16'h0200);
    read_reg(3'd4, v); check(v == 16'h0, "R4 relocked status", v, 0);
    wait_cyc(30);
    read_reg(3'd3, v); check(v == 16'hFFF, "R4 relocked window", v, 12'hFFF);
  endtask

  task automatic t_start_refresh();
    bus_write(3'd0, 16'hCCCC);
    wait_cyc(20);
    check(count >= 12'hFF9 && count <= 12'hFFB, "R2 counting from 0xFFF", count, 12'hFFA);
    bus_write(3'd0, 16'hAAAA);
    check(wdt_rst == 1'b0, "R9 window disabled", wdt_rst, 0);
    check(count == 12'h00A, "R6 refresh load", count, 12'h00A);
  endtask

  task automatic t_expire();
    logic [15:0] v;
    int n = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (wdt_rst) begin n = i; break; end
    end
    check(n >= 41 && n <= 44, "R3 expiry delay", n, 42);
    check(count == 12'hFFF, "R8 count default", count, 12'hFFF);
    read_reg(3'd2, v); check(v == 16'hFFF, "R8 reload default", v, 12'hFFF);
    @(negedge clk);
    check(wdt_rst == 1'b0, "R7 one-cycle pulse", wdt_rst, 0);
    wait_cyc(40);
    check(count == 12'hFFF, "R8 stopped after pulse", count, 12'hFFF);
  endtask

  task automatic t_early();
    logic [15:0] v;
    bus_write(3'd0, 16'h5555);
    bus_write(3'd3, 16'h0100);
    wait_cyc(30);
    bus_write(3'd0, 16'hCCCC);
    wait_cyc(10);
    bus_write(3'd0, 16'hAAAA);
    check(wdt_rst == 1'b1, "R9 early refresh resets", wdt_rst, 1);
    wait_cyc(2);
    read_reg(3'd3, v); check(v == 16'hFFF, "R8 window default", v, 12'hFFF);
  endtask

  task automatic t_window_reload();
    bus_write(3'd0, 16'h5555);
    bus_write(3'd2, 16'h0050);
    wait_cyc(30);
    bus_write(3'd0, 16'hCCCC);
    wait_cyc(20);
    bus_write(3'd0, 16'h5555);
    bus_write(3'd3, 16'h0100);
    wait_cyc(30);
    check(count >= 12'h046 && count <= 12'h050, "R10 window write reloads", count, 12'h04C);
    bus_write(3'd0, 16'hAAAA);
    check(wdt_rst == 1'b0, "R9 refresh inside window", wdt_rst, 0);
    check(count == 12'h050, "R6 refresh inside window", count, 12'h050);
  endtask

  task automatic t_freeze();
    logic [11:0] c0;
    @(negedge clk);
    dbg_halt = 1'b1; halt_en = 1'b1;
    c0 = count;
    wait_cyc(40);
    check(count == c0, "R11 frozen", count, c0);
    halt_en = 1'b0;
    c0 = count;
    wait_cyc(40);
    check((c0 - count) >= 9 && (c0 - count) <= 11, "R11 halt ignored without enable",
          c0 - count, 10);
    dbg_halt = 1'b0;
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    logic [11:0] c0;
    bus_write(3'd0, 16'h5555);
    bus_write(3'd1, 16'h0001);
    wait_cyc(30);
    read_reg(3'd1, v); check(v == 16'h1, "R12 presc applied", v, 1);
    bus_write(3'd0, 16'hAAAA);
    c0 = count;
    wait_cyc(80);
    check((c0 - count) >= 9 && (c0 - count) <= 11, "R12 divide by 8", c0 - count, 10);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset_state();
    t_not_started();
    t_locked_write();
    t_busy_apply();
    t_relock();
    t_start_refresh();
    t_expire();
    t_early();
    t_window_reload();
    t_freeze();
    t_prescale();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule